// File: doc/BRIEF.md
# SDRAM Refresh Scheduler

This block decides when a synchronous DRAM controller must refresh, and it raises the commands for that refresh. An interval timer adds one owed refresh after each fixed period. Owed refreshes are counted up to a set limit. Whenever at least one is owed, the scheduler takes the command bus. If the bank logic reports that any bank is still open, it first asks for a precharge of all banks. It then waits out the precharge recovery time and asks for an AUTO REFRESH. After that it keeps the bus quiet for the refresh cycle time. The row address is generated inside the memory, so the block has no address output.

A low-power request sends the scheduler into self refresh once no refreshes are owed. Self refresh is entered with the same command as a refresh, but CKE is driven low. CKE stays low for at least a minimum time and for as long as the request is held. On exit, CKE goes high and the block stays busy for a recovery period. The owed count is cleared at that point and the interval restarts, because the memory kept itself refreshed while it was in self refresh. The command arbiter gives normal traffic the bus only while `busy` is low. It answers each command request with a one-cycle grant.

Top module: `sdram_refresh_sched`

## Requirements
- R1: While reset is asserted and right after it, `cke` is 1 and `pre_all_req`, `aref_req` and `busy` are 0.
- R2: Every `REFI_CYC` cycles outside self refresh adds one owed refresh. With `banks_idle`=1 and grant given at once, each owed refresh produces an `aref_req` with `cke`=1.
- R3: With `banks_idle`=0, an owed refresh first raises `pre_all_req`. After that request is granted, `aref_req` rises only after `TRP_CYC` full cycles.
- R4: With `banks_idle`=1 when an owed refresh is taken up, no `pre_all_req` is raised, and `aref_req` rises in the next cycle.
- R5: A request stays high until the cycle in which `grant` is 1. `pre_all_req` and `aref_req` are never high together. A grant given while no request is high has no effect.
- R6: After a refresh grant, no request is raised for `TRFC_CYC` cycles.
- R7: The owed count saturates at `MAX_PEND`. After a long stall, the backlog is served back to back, spaced only by the refresh cycle time.
- R8: `lp_req` is acted on only when no refresh is owed. The entry command is an `aref_req` with `cke`=0, preceded by a precharge when `banks_idle`=0.
- R9: After the entry grant, `cke` stays 0 for at least `TRAS_CYC` cycles, and for longer while `lp_req` stays 1, even for a one-cycle request.
- R10: On exit, `cke` returns to 1 and `busy` stays 1 for `TXSR_CYC` cycles. The owed count is then 0, and the next refresh falls `REFI_CYC` cycles after the scheduler goes idle.
- R11: `busy` is 1 exactly when the scheduler is not idle, which includes every cycle with a request high or with `cke`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| banks_idle | input | 1 | All banks closed and recovered |
| lp_req | input | 1 | Request to enter or stay in self refresh |
| grant | input | 1 | Arbiter accepts the current command request |
| pre_all_req | output | 1 | Request for a precharge of all banks |
| aref_req | output | 1 | Request for a refresh command (self refresh entry when `cke`=0) |
| cke | output | 1 | Clock-enable level for the memory |
| busy | output | 1 | Scheduler holds the command bus |

## Verification
The bench goes after the tight corners of the sequence. The first is the precharge recovery gap: a scheduler off by one cycle would raise the refresh request inside tRP. The second is saturation of the owed count during a long stall with no grant: a design that wraps the count would under-refresh, and one that does not cap it would over-refresh. The third is a one-cycle low-power pulse, which must still hold CKE low for the full minimum. The fourth is exit from self refresh: a design that kept the old backlog or the old timer phase would fire a refresh too early. Grants are also given with gaps, and while no request is high, to expose requests that drop or commands that a stray grant accepts.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE_ALL,
    ST_WAIT_RP,
    ST_AREF,
    ST_WAIT_RFC,
    ST_SELF,
    ST_EXIT
  } rfsh_state_e;

  // Bits needed to hold values 0..maxv
  function automatic int unsigned cnt_width(int unsigned maxv);
    return (maxv < 2) ? 1 : $clog2(maxv + 1);
  endfunction

  function automatic int unsigned max4(int unsigned a, int unsigned b,
                                       int unsigned c, int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  // Owed-refresh update: add a tick, remove a served one, clamp at cap
  function automatic int unsigned next_owed(int unsigned cur, logic add,
                                            logic sub, int unsigned cap);
    int unsigned v;
    v = cur + (add ? 1 : 0);
    if (sub && v != 0) v = v - 1;
    return (v > cap) ? cap : v;
  endfunction

endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer
  import rfsh_pkg::*;
#(
  parameter int unsigned REFI_CYC = 1562,
  parameter int unsigned MAX_PEND = 8,
  parameter int unsigned PW       = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic          take,
  output logic          tick,
  output logic [PW-1:0] owed
);
  localparam int unsigned TW = cnt_width(REFI_CYC);

  logic [TW-1:0] tmr_q;

  assign tick = !hold && (tmr_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= TW'(REFI_CYC - 1);
      owed  <= '0;
    end else if (hold) begin
      tmr_q <= TW'(REFI_CYC - 1);
      owed  <= '0;
    end else begin
      tmr_q <= tick ? TW'(REFI_CYC - 1) : tmr_q - 1'b1;
      owed  <= PW'(next_owed(int'(owed), tick, take, MAX_PEND));
    end
  end
endmodule

// File: rtl/rfsh_wait_counter.sv
module rfsh_wait_counter #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt_q;

  assign zero = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (load)  cnt_q <= load_val;
    else if (!zero) cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched
  import rfsh_pkg::*;
#(
  parameter int unsigned REFI_CYC = 1562,
  parameter int unsigned TRP_CYC  = 2,
  parameter int unsigned TRFC_CYC = 7,
  parameter int unsigned TRAS_CYC = 5,
  parameter int unsigned TXSR_CYC = 8,
  parameter int unsigned MAX_PEND = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic banks_idle,
  input  logic lp_req,
  input  logic grant,
  output logic pre_all_req,
  output logic aref_req,
  output logic cke,
  output logic busy
);
  localparam int unsigned WMAX = max4(TRP_CYC, TRFC_CYC, TRAS_CYC, TXSR_CYC);
  localparam int unsigned CW   = cnt_width(WMAX);
  localparam int unsigned PW   = cnt_width(MAX_PEND);
  localparam logic [CW-1:0] LD_RP   = CW'(TRP_CYC - 1);
  localparam logic [CW-1:0] LD_RFC  = CW'(TRFC_CYC - 1);
  localparam logic [CW-1:0] LD_RAS  = CW'(TRAS_CYC - 1);
  localparam logic [CW-1:0] LD_XSR  = CW'(TXSR_CYC - 1);

  rfsh_state_e   st_q, st_d;
  logic          to_self_q, to_self_d;
  logic          wait_ld, wait_zero, take, tick, timer_hold;
  logic [CW-1:0] wait_val;
  logic [PW-1:0] owed;

  assign timer_hold = (st_q == ST_SELF) || (st_q == ST_EXIT);

  rfsh_interval_timer #(
    .REFI_CYC(REFI_CYC), .MAX_PEND(MAX_PEND), .PW(PW)
  ) i_timer (
    .clk(clk), .rst_n(rst_n), .hold(timer_hold), .take(take),
    .tick(tick), .owed(owed)
  );

  rfsh_wait_counter #(.CW(CW)) i_wait (
    .clk(clk), .rst_n(rst_n), .load(wait_ld), .load_val(wait_val),
    .zero(wait_zero)
  );

  always_comb begin
    st_d      = st_q;
    to_self_d = to_self_q;
    wait_ld   = 1'b0;
    wait_val  = '0;
    take      = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (owed != '0) begin
          to_self_d = 1'b0;
          st_d      = banks_idle ? ST_AREF : ST_PRE_ALL;
        end else if (lp_req) begin
          to_self_d = 1'b1;
          st_d      = banks_idle ? ST_AREF : ST_PRE_ALL;
        end
      end
      ST_PRE_ALL: if (grant) begin
        st_d = ST_WAIT_RP; wait_ld = 1'b1; wait_val = LD_RP;
      end
      ST_WAIT_RP: if (wait_zero) st_d = ST_AREF;
      ST_AREF: if (grant) begin
        wait_ld = 1'b1;
        if (to_self_q) begin
          st_d = ST_SELF; wait_val = LD_RAS;
        end else begin
          st_d = ST_WAIT_RFC; wait_val = LD_RFC; take = 1'b1;
        end
      end
      ST_WAIT_RFC: if (wait_zero) st_d = ST_IDLE;
      ST_SELF: if (wait_zero && !lp_req) begin
        st_d = ST_EXIT; wait_ld = 1'b1; wait_val = LD_XSR;
      end
      ST_EXIT: if (wait_zero) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      to_self_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      to_self_q <= to_self_d;
    end
  end

  assign pre_all_req = (st_q == ST_PRE_ALL);
  assign aref_req    = (st_q == ST_AREF);
  assign cke         = !((st_q == ST_SELF) || (st_q == ST_AREF && to_self_q));
  assign busy        = (st_q != ST_IDLE);
endmodule

// File: rtl/rfsh_sched_checker.sv
module rfsh_sched_checker
  import rfsh_pkg::*;
#(
  parameter int unsigned TRP_CYC  = 2,
  parameter int unsigned TRAS_CYC = 5,
  parameter int unsigned MAX_PEND = 8,
  parameter int unsigned PW       = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          banks_idle,
  input logic          grant,
  input logic          pre_all_req,
  input logic          aref_req,
  input logic          cke,
  input logic          busy,
  input rfsh_state_e   st_q,
  input logic [PW-1:0] owed
);
  int unsigned since_pre;
  int unsigned low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_pre <= TRP_CYC;
      low_run   <= 0;
    end else begin
      if (pre_all_req && grant)   since_pre <= 0;
      else if (since_pre < TRP_CYC) since_pre <= since_pre + 1;
      if (cke)                    low_run <= 0;
      else if (low_run < TRAS_CYC + 1) low_run <= low_run + 1;
    end
  end

  a_r3_rp_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aref_req) |-> since_pre >= TRP_CYC);

  a_r4_skip_pre: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && banks_idle && owed != '0) |=> aref_req);

  a_r5_one_req: assert property (@(posedge clk) disable iff (!rst_n)
    !(pre_all_req && aref_req));

  a_r5_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_all_req && !grant) |=> pre_all_req);

  a_r6_rfc_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (aref_req && cke && grant) |=> !(aref_req || pre_all_req));

  a_r7_owed_cap: assert property (@(posedge clk) disable iff (!rst_n)
    int'(owed) <= MAX_PEND);

  a_r9_cke_min: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> low_run >= TRAS_CYC);

  a_r10_exit_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> busy);

  a_r11_busy_cover: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_all_req || aref_req || !cke) |-> busy);
endmodule

bind sdram_refresh_sched rfsh_sched_checker #(
  .TRP_CYC(TRP_CYC), .TRAS_CYC(TRAS_CYC), .MAX_PEND(MAX_PEND), .PW(PW)
) i_rfsh_chk (
  .clk(clk), .rst_n(rst_n), .banks_idle(banks_idle), .grant(grant),
  .pre_all_req(pre_all_req), .aref_req(aref_req), .cke(cke), .busy(busy),
  .st_q(st_q), .owed(owed)
);

// File: tb/test_sdram_refresh_sched.sv
module test_sdram_refresh_sched;
  localparam int REFI = 40;
  localparam int TRP  = 3;
  localparam int TRFC = 5;
  localparam int TRAS = 6;
  localparam int TXSR = 4;
  localparam int MAXP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic banks_idle = 1'b1;
  logic lp_req = 1'b0;
  logic grant = 1'b0;
  logic pre_all_req, aref_req, cke, busy;

  always #5 clk = ~clk;

  sdram_refresh_sched #(
    .REFI_CYC(REFI), .TRP_CYC(TRP), .TRFC_CYC(TRFC),
    .TRAS_CYC(TRAS), .TXSR_CYC(TXSR), .MAX_PEND(MAXP)
  ) i_sdram_refresh_sched (
    .clk(clk), .rst_n(rst_n), .banks_idle(banks_idle), .lp_req(lp_req),
    .grant(grant), .pre_all_req(pre_all_req), .aref_req(aref_req),
    .cke(cke), .busy(busy)
  );

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  int gmode = 1;          // 0 never grant, 1 always, 2 every third cycle
  string cur_req = "R1";

  // Behavioural reference: phase names as strings, ages as integers
  string m_phase = "idle";
  int m_age = 0;          // cycles since the interval last restarted
  int m_owed = 0;
  int m_left = 0;
  bit m_sleep = 1'b0;     // current sequence ends in self refresh

  function automatic bit exp_pre();  return m_phase == "pre";  endfunction
  function automatic bit exp_aref(); return m_phase == "aref"; endfunction
  function automatic bit exp_cke();
    return !(m_phase == "self" || (m_phase == "aref" && m_sleep));
  endfunction
  function automatic bit exp_busy(); return m_phase != "idle"; endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = "idle"; m_age = 0; m_owed = 0; m_left = 0; m_sleep = 1'b0;
    end else begin
      bit ticked, served;
      bit asleep;
      asleep = (m_phase == "self" || m_phase == "exit");
      ticked = 1'b0;
      served = (m_phase == "aref") && grant && !m_sleep;
      if (!asleep) begin
        ticked = (m_age == REFI - 1);
        m_age = ticked ? 0 : m_age + 1;
      end
      if (m_phase == "idle") begin
        if (m_owed > 0 || lp_req) begin
          m_sleep = (m_owed == 0);
          m_phase = banks_idle ? "aref" : "pre";
        end
      end else if (m_phase == "pre") begin
        if (grant) begin m_phase = "rp"; m_left = TRP; end
      end else if (m_phase == "rp") begin
        m_left--; if (m_left == 0) m_phase = "aref";
      end else if (m_phase == "aref") begin
        if (grant) begin
          if (m_sleep) begin m_phase = "self"; m_left = TRAS; end
          else begin m_phase = "rfc"; m_left = TRFC; end
        end
      end else if (m_phase == "rfc") begin
        m_left--; if (m_left == 0) m_phase = "idle";
      end else if (m_phase == "self") begin
        if (m_left > 0) m_left--;
        if (m_left == 0 && !lp_req) begin m_phase = "exit"; m_left = TXSR; end
      end else begin
        m_left--; if (m_left == 0) m_phase = "idle";
      end
      if (asleep) begin
        m_owed = 0; m_age = 0;
      end else begin
        m_owed = m_owed + (ticked ? 1 : 0) - (served ? 1 : 0);
        if (m_owed > MAXP) m_owed = MAXP;
      end
    end
  end

  task automatic check(string what, logic act, logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s at cycle %0d: actual %b expected %b",
               cur_req, what, cyc, act, exp);
    end
  endtask

  // Compare away from the active edge, then drive the grant for the next edge
  always @(negedge clk) begin
    cyc++;
    check("pre_all_req", pre_all_req, exp_pre());
    check("aref_req", aref_req, exp_aref());
    check("cke", cke, exp_cke());
    check("busy", busy, exp_busy());
    if (pre_all_req && aref_req) check("R5 exclusive requests", 1'b1, 1'b0);
    case (gmode)
      0: grant = 1'b0;
      1: grant = 1'b1;
      default: grant = (cyc % 3 == 0);
    endcase
  end

  task automatic run(string tag, int n);
    cur_req = tag;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    run("R1", 3);
    rst_n = 1'b1;
    run("R1", 2);
    banks_idle = 1'b1; gmode = 1;
    run("R2", 45);
    run("R4", 45);
    banks_idle = 1'b0;
    run("R3", 50);
    gmode = 2;
    run("R5", 90);
    banks_idle = 1'b1; gmode = 1;
    run("R6", 50);
    gmode = 0; banks_idle = 1'b0;
    run("R7", 6 * REFI);
    gmode = 1; banks_idle = 1'b1;
    run("R7", 60);
    lp_req = 1'b1; banks_idle = 1'b0;
    run("R8", 35);
    run("R9", 30);
    lp_req = 1'b0;
    run("R10", 20);
    lp_req = 1'b1;
    run("R9", 1);
    lp_req = 1'b0;
    run("R9", 30);
    run("R10", 50);
    gmode = 2;
    for (int k = 0; k < 8; k++) begin
      banks_idle = k[0];
      run("R11", 25);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule